// File: doc/BRIEF.md
# Colour Lookup Table Store

This block holds the colour lookup table of a display controller. It keeps 128 words of 32 bits each. Each word carries two 16-bit colour entries, so the table has 256 entries. Software reaches the words through a plain register port that decodes byte offsets in the controller's register window. The pixel path reaches the table through a streaming lookup port: it presents an 8-bit entry index and gets back a 24-bit colour.

Each 16-bit entry packs three 5-bit components, and the top bit of the entry is unused. The lookup port widens each component to 8 bits. Software reads always return the raw 32-bit word as it was written.

Any write that lands in the table raises a one-cycle redraw request. The rest of the controller uses it to schedule a full repaint of the screen.

The lookup port follows valid/ready rules on both sides:
- A request is taken on a cycle where `lk_valid` and `lk_ready` are both high.
- `lk_ready` is high whenever the output slot is empty or is being drained in the same cycle.
- A result offered with `px_valid` stays fixed until the cycle where `px_ready` is high.

Top module: `clut_ram`

## Requirements
- R1: Table word n (0 to 127) sits at byte offset 0x200 + 4n; bits 1:0 of the offset are ignored. A read returns all 32 bits last written to that word, including bits 15 and 31.
- R2: A write at an offset below 0x200 or at 0x400 and above changes no table word. A read at such an offset returns zero.
- R3: A lookup of an even index i returns the entry in bits 15:0 of word i/2. A lookup of an odd index returns the entry in bits 31:16 of that word.
- R4: Within an entry, bits 4:0 are red, bits 9:5 are green and bits 14:10 are blue, and bit 15 has no effect on the result. `px_rgb` carries red in bits 23:16, green in 15:8 and blue in 7:0. Each 8-bit component is its 5-bit value followed by three zero bits.
- R5: A lookup taken at a clock edge shows its result with `px_valid` high right after that edge.
- R6: A lookup taken in the same cycle as a write to the word that holds its entry returns the value from before the write.
- R7: While `px_valid` is high and `px_ready` is low, `px_rgb` and `px_valid` hold and `lk_ready` is low.
- R8: The cycle after every in-range write, `redraw_req` is high for exactly one cycle. An out-of-range write does not raise it.
- R9: After reset, every table word reads zero. In addition `px_valid`, `redraw_req` and `reg_rdata` are zero, and `lk_ready` is high.
- R10: A register read shows its data one cycle after `reg_ren`. A read and a write to the same word in the same cycle return the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Byte offset in the register window |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_ren`, held otherwise |
| redraw_req | output | 1 | One-cycle pulse after a table write |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high |
| lk_index | input | 8 | Entry index to look up |
| px_valid | output | 1 | Colour result valid |
| px_ready | input | 1 | Consumer accepts the colour result |
| px_rgb | output | 24 | Expanded colour, red in the high byte |

## Verification
A corrupted table word is visible one cycle after a register read of that word. It is also visible in the colour returned for either of the two entries the word holds. A wrong half or component selection changes `px_rgb` on the next lookup, so every vector looks up both neighbouring entries. A wrong output-slot state shows in the same cycle as `lk_ready` or as a result changing under a stall. A lost or extra write strobe shows one cycle later on `redraw_req`.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int unsigned COMP_IN_W  = 5;
  localparam int unsigned COMP_OUT_W = 8;
  localparam int unsigned N_COMP     = 3;
  localparam int unsigned RGB_W      = N_COMP * COMP_OUT_W;

  // Output byte order: red high, blue low.
  typedef enum logic [1:0] {
    COMP_RED   = 2'd0,
    COMP_GREEN = 2'd1,
    COMP_BLUE  = 2'd2
  } comp_e;
endpackage

// File: rtl/clut_decode.sv
module clut_decode #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BASE   = 'h200,
  parameter int unsigned WORDS  = 128,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(WORDS * 4);

  logic [ADDR_W-1:0] off;
  logic              unused_bits;

  always_comb begin
    off = addr - BASE_A;
    hit = (addr >= BASE_A) && (off < SPAN_A);
    idx = off[IDX_W+1:2];
  end

  assign unused_bits = ^{off[1:0], off[ADDR_W-1:IDX_W+2]};
endmodule

// File: rtl/clut_store.sv
module clut_store #(
  parameter int unsigned WORDS  = 128,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < int'(WORDS); w++) mem[w] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  // Reads see the contents before any write at this edge.
  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
endmodule

// File: rtl/clut_expand.sv
module clut_expand
  import clut_pkg::*;
#(
  parameter int unsigned ENTRY_W = 16
) (
  input  logic [ENTRY_W-1:0] entry,
  output logic [RGB_W-1:0]   rgb
);
  localparam int unsigned PAD_W = COMP_OUT_W - COMP_IN_W;

  for (genvar c = 0; c < int'(N_COMP); c++) begin : g_comp
    localparam int unsigned OUT_LSB = (N_COMP - 1 - c) * COMP_OUT_W;
    assign rgb[OUT_LSB +: COMP_OUT_W] = {entry[c*COMP_IN_W +: COMP_IN_W], {PAD_W{1'b0}}};
  end

  logic unused_top;
  assign unused_top = ^entry[ENTRY_W-1:N_COMP*COMP_IN_W];
endmodule

// File: rtl/clut_lookup.sv
module clut_lookup
  import clut_pkg::*;
#(
  parameter int unsigned WORDS  = 128,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned ENT_W = IDX_W + 1,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ENT_W-1:0]  lk_index,
  output logic [IDX_W-1:0]  word_idx,
  input  logic [DATA_W-1:0] word_data,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [RGB_W-1:0]  px_rgb
);
  logic              slot_q;
  logic [RGB_W-1:0]  rgb_q;
  logic [HALF_W-1:0] entry;
  logic [RGB_W-1:0]  rgb_d;
  logic              take;

  assign word_idx = lk_index[ENT_W-1:1];
  assign entry    = lk_index[0] ? word_data[DATA_W-1:HALF_W] : word_data[HALF_W-1:0];

  clut_expand #(.ENTRY_W(HALF_W)) u_expand (
    .entry (entry),
    .rgb   (rgb_d)
  );

  assign lk_ready = !slot_q || px_ready;
  assign take     = lk_valid && lk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= 1'b0;
      rgb_q  <= '0;
    end else begin
      if (take) begin
        slot_q <= 1'b1;
        rgb_q  <= rgb_d;
      end else if (px_ready) begin
        slot_q <= 1'b0;
      end
    end
  end

  assign px_valid = slot_q;
  assign px_rgb   = rgb_q;
endmodule

// File: rtl/clut_ram.sv
module clut_ram
  import clut_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BASE   = 'h200,
  parameter int unsigned WORDS  = 128,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned ENT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic              reg_ren,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              redraw_req,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ENT_W-1:0]  lk_index,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [RGB_W-1:0]  px_rgb
);
  logic              hit;
  logic [IDX_W-1:0]  ridx;
  logic [IDX_W-1:0]  lk_word;
  logic [DATA_W-1:0] ra_data;
  logic [DATA_W-1:0] rb_data;
  logic [DATA_W-1:0] rdata_q;
  logic              redraw_q;

  clut_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .WORDS(WORDS)) u_decode (
    .addr (reg_addr),
    .hit  (hit),
    .idx  (ridx)
  );

  clut_store #(.WORDS(WORDS), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_wen && hit),
    .widx    (ridx),
    .wdata   (reg_wdata),
    .ra_idx  (ridx),
    .ra_data (ra_data),
    .rb_idx  (lk_word),
    .rb_data (rb_data)
  );

  clut_lookup #(.WORDS(WORDS), .DATA_W(DATA_W)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_ready  (lk_ready),
    .lk_index  (lk_index),
    .word_idx  (lk_word),
    .word_data (rb_data),
    .px_valid  (px_valid),
    .px_ready  (px_ready),
    .px_rgb    (px_rgb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      redraw_q <= 1'b0;
    end else begin
      redraw_q <= reg_wen && hit;
      if (reg_ren) rdata_q <= hit ? ra_data : '0;
    end
  end

  assign reg_rdata  = rdata_q;
  assign redraw_req = redraw_q;
endmodule

// File: rtl/clut_ram_chk.sv
module clut_ram_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BASE   = 'h200,
  parameter int unsigned WORDS  = 128,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ENT_W  = 8,
  parameter int unsigned RGB_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wen,
  input logic              reg_ren,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              redraw_req,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic [ENT_W-1:0]  lk_index,
  input logic              px_valid,
  input logic              px_ready,
  input logic [RGB_W-1:0]  px_rgb
);
  logic in_win;
  assign in_win = (32'(reg_addr) >= BASE) && (32'(reg_addr) < BASE + WORDS * 4);

  logic unused_idx;
  assign unused_idx = ^lk_index;

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_ren && !in_win) |=> (reg_rdata == '0)); // R2

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> (px_rgb[2:0] == 3'b0 && px_rgb[10:8] == 3'b0 && px_rgb[18:16] == 3'b0)); // R4

  AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> px_valid); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |=> (px_valid && $stable(px_rgb))); // R7

  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |-> !lk_ready); // R7

  AST_REDRAW_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && in_win) |=> redraw_req); // R8

  AST_NO_REDRAW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wen && in_win) |=> !redraw_req); // R8

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_ren |=> $stable(reg_rdata)); // R10
endmodule

bind clut_ram clut_ram_chk #(
  .ADDR_W(ADDR_W), .BASE(BASE), .WORDS(WORDS), .DATA_W(DATA_W),
  .ENT_W(ENT_W), .RGB_W(clut_pkg::RGB_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
  .reg_ren(reg_ren), .reg_rdata(reg_rdata), .redraw_req(redraw_req),
  .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_index(lk_index),
  .px_valid(px_valid), .px_ready(px_ready), .px_rgb(px_rgb)
);

// File: tb/clut_ram_tb_top.sv
module clut_ram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic        reg_ren = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        redraw_req;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [7:0]  lk_index = '0;
  logic        px_valid;
  logic        px_ready = 1'b1;
  logic [23:0] px_rgb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clut_ram dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_ren(reg_ren), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .redraw_req(redraw_req), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_index(lk_index), .px_valid(px_valid), .px_ready(px_ready), .px_rgb(px_rgb)
  );

  localparam logic [31:0] VEC [8] = '{
    32'h8000_7FFF, 32'h7C00_03E0, 32'h001F_8421, 32'hFFFF_0000,
    32'h1234_5678, 32'hA5A5_5A5A, 32'h0001_8000, 32'hDEAD_BEEF
  };

  function automatic logic [23:0] colour(input logic [15:0] e);
    return {e[4:0], 3'b000, e[9:5], 3'b000, e[14:10], 3'b000};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit exp_redraw);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
    check(redraw_req == exp_redraw, "R8 redraw after write", 32'(redraw_req), 32'(exp_redraw));
    @(negedge clk);
    check(redraw_req == 1'b0, "R8 redraw single cycle", 32'(redraw_req), 0);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_ren = 1'b1;
    @(negedge clk);
    reg_ren = 1'b0;
    d = reg_rdata;
  endtask

  task automatic look(input logic [7:0] idx, output logic [23:0] c);
    @(negedge clk);
    lk_index = idx; lk_valid = 1'b1; px_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    check(px_valid == 1'b1, "R5 result valid one cycle after accept", 32'(px_valid), 1);
    c = px_rgb;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [23:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(px_valid == 1'b0, "R9 px_valid after reset", 32'(px_valid), 0);
    check(redraw_req == 1'b0, "R9 redraw after reset", 32'(redraw_req), 0);
    check(reg_rdata == 32'h0, "R9 rdata after reset", reg_rdata, 0);
    check(lk_ready == 1'b1, "R9 lk_ready after reset", 32'(lk_ready), 1);
    rd(12'h3FC, d);
    check(d == 32'h0, "R9 word 127 cleared", d, 0);
    look(8'd9, c);
    check(c == 24'h0, "R9 entry 9 cleared", 32'(c), 0);

    // Vector table: R1 R3 R4
    for (int i = 0; i < 8; i++) begin
      int w;
      w = (i * 37 + 3) % 128;
      wr(12'(32'h200 + 4 * w), VEC[i], 1'b1);
      rd(12'(32'h200 + 4 * w + (i % 4)), d);
      check(d == VEC[i], "R1 raw word readback", d, VEC[i]);
      look(8'(2 * w), c);
      check(c == colour(VEC[i][15:0]), "R3 R4 even entry colour", 32'(c), 32'(colour(VEC[i][15:0])));
      look(8'(2 * w + 1), c);
      check(c == colour(VEC[i][31:16]), "R3 R4 odd entry colour", 32'(c), 32'(colour(VEC[i][31:16])));
    end

    // Boundary words and out-of-range accesses: R2
    wr(12'h200, 32'h1111_2222, 1'b1);
    wr(12'h3FC, 32'h3333_4444, 1'b1);
    look(8'd255, c);
    check(c == colour(16'h3333), "R3 top entry 255", 32'(c), 32'(colour(16'h3333)));
    wr(12'h1FC, 32'hFFFF_FFFF, 1'b0);
    wr(12'h400, 32'hFFFF_FFFF, 1'b0);
    rd(12'h200, d);
    check(d == 32'h1111_2222, "R2 word 0 untouched", d, 32'h1111_2222);
    rd(12'h3FC, d);
    check(d == 32'h3333_4444, "R2 word 127 untouched", d, 32'h3333_4444);
    rd(12'h1FC, d);
    check(d == 32'h0, "R2 read below window", d, 0);
    rd(12'h200, d);
    rd(12'h400, d);
    check(d == 32'h0, "R2 read above window", d, 0);

    // R6 write and lookup in the same cycle
    wr(12'(32'h200 + 4 * 50), 32'h0000_001F, 1'b1);
    @(negedge clk);
    reg_addr = 12'(32'h200 + 4 * 50); reg_wdata = 32'h7C00_03E0; reg_wen = 1'b1;
    lk_index = 8'd100; lk_valid = 1'b1; px_ready = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0; lk_valid = 1'b0;
    check(px_rgb == 24'hF80000, "R6 same-cycle lookup sees old entry", 32'(px_rgb), 32'hF80000);
    look(8'd100, c);
    check(c == 24'h00F800, "R6 later lookup sees new entry", 32'(c), 32'h00F800);

    // R10 read and write same word in the same cycle
    wr(12'(32'h200 + 4 * 51), 32'hCAFE_0001, 1'b1);
    @(negedge clk);
    reg_addr = 12'(32'h200 + 4 * 51); reg_wdata = 32'h0BAD_0002; reg_wen = 1'b1; reg_ren = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0; reg_ren = 1'b0;
    check(reg_rdata == 32'hCAFE_0001, "R10 same-cycle read returns old", reg_rdata, 32'hCAFE_0001);
    rd(12'(32'h200 + 4 * 51), d);
    check(d == 32'h0BAD_0002, "R10 later read returns new", d, 32'h0BAD_0002);

    // R7 back-pressure
    @(negedge clk);
    px_ready = 1'b0; lk_index = 8'd100; lk_valid = 1'b1;
    @(negedge clk);
    check(px_valid == 1'b1, "R7 result offered", 32'(px_valid), 1);
    check(lk_ready == 1'b0, "R7 not ready while stalled", 32'(lk_ready), 0);
    lk_index = 8'd101;
    @(negedge clk);
    check(px_rgb == 24'h00F800, "R7 result held under stall", 32'(px_rgb), 32'h00F800);
    check(px_valid == 1'b1, "R7 valid held under stall", 32'(px_valid), 1);
    px_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    check(px_rgb == 24'h0000F8, "R7 next request after drain", 32'(px_rgb), 32'h0000F8);
    @(negedge clk);
    check(px_valid == 1'b0, "R7 slot empties", 32'(px_valid), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule